// File: doc/BRIEF.md
# Synchronous Burst Bus Master

This block sits between a processor-side requester and an external synchronous memory bus. It turns single read and write requests, and four-beat block reads, into clocked commands on a 64-bit bus. The bus is split into an even 32-bit lane in bits [31:0] and an odd 32-bit lane in bits [63:32]. Each lane has its own active-low read strobe and its own active-low write strobe. The bus also carries a chip select, a burst-start line and an acknowledge input from the slave. Every output changes just after a rising clock edge, and every input is sampled on one.

The requester presents a request with a valid/ready handshake: `req_valid` and `req_ready` both high at a rising edge means the request is accepted. One request is in flight at a time. The block answers with a one-cycle `rsp_done` pulse in the cycle right after the edge that completed the access. A read also pulses `rsp_beat` and presents the captured data on `rsp_rdata`; a burst does this once per beat. A burst request that is not a full-width read is refused without touching the bus. A slave that never holds the bus off can tie `mem_ack` high, and then no access stalls.

Top module: `sbm_master`

## Requirements
- R1: Lane selection. A single-lane access with `req_addr[0]`=0 drives only the even-lane strobe (`mem_rd_lo_n` or `mem_wr_lo_n` low). With `req_addr[0]`=1 it drives only the odd-lane strobe (`mem_rd_hi_n` or `mem_wr_hi_n` low). A wide access (`req_wide`=1) drives both strobes of the chosen direction. The strobes of the other direction stay high.
- R2: Data lanes. `mem_wdata` carries the request's write data, with even-lane data in bits [31:0] and odd-lane data in bits [63:32]. `rsp_rdata` returns the data captured from `mem_rdata` in the same lanes, with any lane that was not selected returned as zero.
- R3: Write timing. After a write is accepted, the next cycle drives the write strobes, `mem_addr`, `mem_wdata` and `mem_wdata_oe`=1. Each rising edge that samples `mem_ack`=0 keeps all of these unchanged for one more cycle. The edge that samples `mem_ack`=1 ends the write, and `rsp_done`=1 with `rsp_err`=0 follows in the next cycle.
- R4: Read timing. After a read is accepted, the address phase holds the read strobes until an edge samples `mem_ack`=1. The data phase then holds them until an edge samples `mem_ack`=1, and that edge captures `mem_rdata`. `rsp_beat`=1, `rsp_done`=1 and the data follow in the next cycle. When `mem_ack` stays high, the read occupies exactly two bus cycles.
- R5: Burst read. `req_burst`=1 with `req_wide`=1 and `req_wr`=0 gives one address phase followed by four data beats. In beat b, the low two bits of `mem_addr` are the start row's low two bits plus b, modulo 4. The upper bits do not change. `mem_burst` is high in the address phase and in beats 0 to 2, and low in the last beat. Each captured beat gives an `rsp_beat` pulse with its data. `rsp_done` comes only with the fourth beat.
- R6: Burst rejection. A burst request that is a write or is not wide is answered in the next cycle with `rsp_done`=1 and `rsp_err`=1. `mem_cs_n` stays high, so no command is issued.
- R7: Idle bus. While no access is running, `mem_cs_n`=1, all four strobes are high, `mem_burst`=0 and `req_ready`=1. `req_ready` is 0 during an access.
- R8: Reset state. While `rst_n` is low and after it is released, the bus is idle (as in R7) and `rsp_done`, `rsp_err`, `rsp_beat` and `rsp_rdata` are zero.
- R9: Addressing. `mem_addr` is the 64-bit row address `req_addr[ADDR_W-1:1]` throughout a single access. `req_addr[0]` only selects the lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | Access both lanes (64-bit) |
| req_burst | input | 1 | Four-beat block read |
| req_addr | input | ADDR_W | 32-bit word address; bit 0 picks the odd lane |
| req_wdata | input | 2*HALF_W | Write data, even lane low |
| rsp_done | output | 1 | Access finished (one cycle) |
| rsp_err | output | 1 | Request refused (with rsp_done) |
| rsp_beat | output | 1 | Read data valid on rsp_rdata |
| rsp_rdata | output | 2*HALF_W | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_lo_n | output | 1 | Even-lane read strobe |
| mem_rd_hi_n | output | 1 | Odd-lane read strobe |
| mem_wr_lo_n | output | 1 | Even-lane write strobe |
| mem_wr_hi_n | output | 1 | Odd-lane write strobe |
| mem_burst | output | 1 | Burst in progress / start of burst counter |
| mem_addr | output | ADDR_W-1 | Row address |
| mem_wdata | output | 2*HALF_W | Write data to the bus |
| mem_wdata_oe | output | 1 | Write data drive enable |
| mem_rdata | input | 2*HALF_W | Read data from the bus |
| mem_ack | input | 1 | Slave acknowledge |

## Verification
The bench builds the block with ADDR_W=10, HALF_W=32 and BURST_LEN=4. The narrow address gives a 9-bit row, so random start rows often land on low bits 2'b01 to 2'b11. That exercises the modulo-4 wrap of burst addresses, and directed cases pin the 2'b00 and 2'b11 starts. Acknowledge is driven both tied high, which checks the minimum-cycle read and write timing, and randomly withheld in address, data and write phases, which checks stretching and the hold of strobes, address and data. Random mixes of write, wide and burst bits give a steady stream of refused burst requests between legal ones.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_RADDR = 2'd2,
    ST_RDATA = 2'd3
  } sbm_state_e;

  typedef struct packed {
    logic wr;
    logic wide;
    logic burst;
    logic odd;
  } sbm_cmd_t;

  // Lane enables: bit 0 = even lane, bit 1 = odd lane.
  function automatic logic [1:0] lane_mask(input sbm_cmd_t c);
    if (c.wide) return 2'b11;
    return c.odd ? 2'b10 : 2'b01;
  endfunction

  // Bursts exist only as full-width reads.
  function automatic logic cmd_legal(input sbm_cmd_t c);
    return !c.burst || (c.wide && !c.wr);
  endfunction

endpackage

// File: rtl/sbm_seq.sv
module sbm_seq
  import sbm_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int BEAT_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_wr,
  input  logic              burst_q,
  input  logic              ack,
  output sbm_state_e        state,
  output logic [BEAT_W-1:0] beat,
  output logic              last_beat,
  output logic              ev_wr_done,
  output logic              ev_beat_cap,
  output logic              ev_last
);

  localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BURST_LEN - 1);

  sbm_state_e state_nx;

  assign last_beat   = !burst_q || (beat == LAST_IDX);
  assign ev_wr_done  = (state == ST_WRITE) && ack;
  assign ev_beat_cap = (state == ST_RDATA) && ack;
  assign ev_last     = ev_beat_cap && last_beat;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start) state_nx = start_wr ? ST_WRITE : ST_RADDR;
      ST_WRITE: if (ack) state_nx = ST_IDLE;
      ST_RADDR: if (ack) state_nx = ST_RDATA;
      ST_RDATA: if (ev_last) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      beat  <= '0;
    end else begin
      state <= state_nx;
      if (state != ST_RDATA) beat <= '0;
      else if (ev_beat_cap && !last_beat) beat <= beat + 1'b1;
    end
  end

endmodule

// File: rtl/sbm_pin_enc.sv
module sbm_pin_enc
  import sbm_pkg::*;
#(
  parameter int ROW_W  = 23,
  parameter int BEAT_W = 2
) (
  input  sbm_state_e        state,
  input  logic [1:0]        lanes,
  input  logic              burst_q,
  input  logic              last_beat,
  input  logic [BEAT_W-1:0] beat,
  input  logic [ROW_W-1:0]  base_row,
  output logic              cs_n,
  output logic              rd_lo_n,
  output logic              rd_hi_n,
  output logic              wr_lo_n,
  output logic              wr_hi_n,
  output logic              burst,
  output logic [ROW_W-1:0]  addr,
  output logic              wdata_oe
);

  // Linear wrap inside an aligned group of BURST_LEN rows.
  function automatic logic [ROW_W-1:0] beat_row(input logic [ROW_W-1:0] base,
                                                 input logic [BEAT_W-1:0] b);
    logic [ROW_W-1:0] r;
    r = base;
    r[BEAT_W-1:0] = base[BEAT_W-1:0] + b;
    return r;
  endfunction

  logic rd_on, wr_on;

  assign rd_on    = (state == ST_RADDR) || (state == ST_RDATA);
  assign wr_on    = (state == ST_WRITE);
  assign cs_n     = (state == ST_IDLE);
  assign rd_lo_n  = !(rd_on && lanes[0]);
  assign rd_hi_n  = !(rd_on && lanes[1]);
  assign wr_lo_n  = !(wr_on && lanes[0]);
  assign wr_hi_n  = !(wr_on && lanes[1]);
  assign wdata_oe = wr_on;
  assign burst    = burst_q && ((state == ST_RADDR) || ((state == ST_RDATA) && !last_beat));
  assign addr     = (state == ST_RDATA) ? beat_row(base_row, beat) : base_row;

endmodule

// File: rtl/sbm_rsp.sv
module sbm_rsp #(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_done,
  input  logic                ev_reject,
  input  logic                ev_beat_cap,
  input  logic [1:0]          lanes,
  input  logic [2*HALF_W-1:0] bus_rdata,
  output logic                done,
  output logic                err,
  output logic                beat,
  output logic [2*HALF_W-1:0] rdata
);

  function automatic logic [2*HALF_W-1:0] lane_keep(input logic [2*HALF_W-1:0] d,
                                                    input logic [1:0] m);
    return {(m[1] ? d[2*HALF_W-1:HALF_W] : {HALF_W{1'b0}}),
            (m[0] ? d[HALF_W-1:0]        : {HALF_W{1'b0}})};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      err   <= 1'b0;
      beat  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= ev_done || ev_reject;
      err  <= ev_reject;
      beat <= ev_beat_cap;
      if (ev_beat_cap) rdata <= lane_keep(bus_rdata, lanes);
    end
  end

endmodule

// File: rtl/sbm_master.sv
module sbm_master
  import sbm_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int HALF_W    = 32,
  parameter int BURST_LEN = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_wr,
  input  logic                req_wide,
  input  logic                req_burst,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*HALF_W-1:0] req_wdata,
  output logic                rsp_done,
  output logic                rsp_err,
  output logic                rsp_beat,
  output logic [2*HALF_W-1:0] rsp_rdata,
  output logic                mem_cs_n,
  output logic                mem_rd_lo_n,
  output logic                mem_rd_hi_n,
  output logic                mem_wr_lo_n,
  output logic                mem_wr_hi_n,
  output logic                mem_burst,
  output logic [ADDR_W-2:0]   mem_addr,
  output logic [2*HALF_W-1:0] mem_wdata,
  output logic                mem_wdata_oe,
  input  logic [2*HALF_W-1:0] mem_rdata,
  input  logic                mem_ack
);

  localparam int ROW_W  = ADDR_W - 1;
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  sbm_state_e         state;
  sbm_cmd_t           in_cmd, cmd_q;
  logic [ROW_W-1:0]   row_q;
  logic [2*HALF_W-1:0] wdata_q;
  logic [BEAT_W-1:0]  beat;
  logic [1:0]         lanes;
  logic               accept, ev_start, ev_reject;
  logic               last_beat, ev_wr_done, ev_beat_cap, ev_last;

  assign in_cmd    = '{wr: req_wr, wide: req_wide, burst: req_burst, odd: req_addr[0]};
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign ev_start  = accept && cmd_legal(in_cmd);
  assign ev_reject = accept && !cmd_legal(in_cmd);
  assign lanes     = lane_mask(cmd_q);
  assign mem_wdata = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      row_q   <= '0;
      wdata_q <= '0;
    end else if (ev_start) begin
      cmd_q   <= in_cmd;
      row_q   <= req_addr[ADDR_W-1:1];
      wdata_q <= req_wdata;
    end
  end

  sbm_seq #(.BURST_LEN(BURST_LEN), .BEAT_W(BEAT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(ev_start), .start_wr(in_cmd.wr),
    .burst_q(cmd_q.burst), .ack(mem_ack), .state(state), .beat(beat),
    .last_beat(last_beat), .ev_wr_done(ev_wr_done),
    .ev_beat_cap(ev_beat_cap), .ev_last(ev_last)
  );

  sbm_pin_enc #(.ROW_W(ROW_W), .BEAT_W(BEAT_W)) u_pins (
    .state(state), .lanes(lanes), .burst_q(cmd_q.burst), .last_beat(last_beat),
    .beat(beat), .base_row(row_q), .cs_n(mem_cs_n), .rd_lo_n(mem_rd_lo_n),
    .rd_hi_n(mem_rd_hi_n), .wr_lo_n(mem_wr_lo_n), .wr_hi_n(mem_wr_hi_n),
    .burst(mem_burst), .addr(mem_addr), .wdata_oe(mem_wdata_oe)
  );

  sbm_rsp #(.HALF_W(HALF_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .ev_done(ev_wr_done || ev_last),
    .ev_reject(ev_reject), .ev_beat_cap(ev_beat_cap), .lanes(lanes),
    .bus_rdata(mem_rdata), .done(rsp_done), .err(rsp_err), .beat(rsp_beat),
    .rdata(rsp_rdata)
  );

endmodule

// File: rtl/sbm_master_chk.sv
module sbm_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic rd_lo_n,
  input logic rd_hi_n,
  input logic wr_lo_n,
  input logic wr_hi_n,
  input logic burst,
  input logic ack,
  input logic ready,
  input logic done,
  input logic err,
  input logic ev_reject,
  input logic ev_wr_done
);

  logic rd_any, wr_any;
  assign rd_any = !rd_lo_n || !rd_hi_n;
  assign wr_any = !wr_lo_n || !wr_hi_n;

  p_no_dir_mix_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_any && wr_any));

  p_wr_stretch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !ack) |=> (wr_any && $stable({wr_lo_n, wr_hi_n})));

  p_wr_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_done |=> (done && !err));

  p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && !ack) |=> (rd_any && $stable({rd_lo_n, rd_hi_n})));

  p_burst_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    burst |-> (!rd_lo_n && !rd_hi_n && !wr_any && !cs_n));

  p_reject_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (cs_n && done && err));

  p_err_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!rd_any && !wr_any && !burst && ready));

  p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);

endmodule

bind sbm_master sbm_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(mem_cs_n), .rd_lo_n(mem_rd_lo_n),
  .rd_hi_n(mem_rd_hi_n), .wr_lo_n(mem_wr_lo_n), .wr_hi_n(mem_wr_hi_n),
  .burst(mem_burst), .ack(mem_ack), .ready(req_ready), .done(rsp_done),
  .err(rsp_err), .ev_reject(ev_reject), .ev_wr_done(ev_wr_done)
);

// File: tb/sbm_master_tb.sv
module sbm_master_tb;

  localparam int AW = 10;
  localparam int HW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_wr = 1'b0, req_wide = 1'b0, req_burst = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0]   req_wdata = '0;
  logic          req_ready, rsp_done, rsp_err, rsp_beat;
  logic [63:0]   rsp_rdata;
  logic          mem_cs_n, mem_rd_lo_n, mem_rd_hi_n, mem_wr_lo_n, mem_wr_hi_n, mem_burst;
  logic [AW-2:0] mem_addr;
  logic [63:0]   mem_wdata;
  logic          mem_wdata_oe;
  logic [63:0]   mem_rdata = '0;
  logic          mem_ack = 1'b1;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sbm_master #(.ADDR_W(AW), .HALF_W(HW), .BURST_LEN(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_wide(req_wide), .req_burst(req_burst),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_err(rsp_err), .rsp_beat(rsp_beat), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_rd_lo_n(mem_rd_lo_n), .mem_rd_hi_n(mem_rd_hi_n),
    .mem_wr_lo_n(mem_wr_lo_n), .mem_wr_hi_n(mem_wr_hi_n), .mem_burst(mem_burst),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_lanes(input bit wide, input bit odd);
    if (wide) return 2'b11;
    return odd ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [63:0] keep_lanes(input logic [63:0] d, input logic [1:0] m);
    logic [63:0] r;
    r = d;
    if (!m[0]) r[31:0] = 32'h0;
    if (!m[1]) r[63:32] = 32'h0;
    return r;
  endfunction

  function automatic logic [AW-2:0] exp_row(input logic [AW-2:0] base, input int b);
    logic [AW-2:0] r;
    r = base;
    r[1:0] = base[1:0] + 2'(b);
    return r;
  endfunction

  task automatic run(input bit wr, input bit wide, input bit burst, input logic [AW-1:0] addr,
                     input logic [63:0] wd, input int pct, input int forced);
    logic [AW-2:0] row;
    logic [1:0]    ln;
    logic [63:0]   last_rd;
    bit            legal, a;
    int            nb, frc;
    row     = addr[AW-1:1];
    ln      = exp_lanes(wide, addr[0]);
    legal   = !burst || (wide && !wr);
    nb      = burst ? 4 : 1;
    frc     = forced;
    last_rd = '0;
    chk(req_ready == 1'b1, "R7", "ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_wr = wr; req_wide = wide; req_burst = burst;
    req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (!legal) begin
      chk(rsp_done && rsp_err, "R6", "reject response", {62'd0, rsp_done, rsp_err}, 64'd3);
      chk(mem_cs_n == 1'b1, "R6", "no command on reject", 64'(mem_cs_n), 64'd1);
      return;
    end
    if (wr) begin
      do begin
        chk({mem_wr_hi_n, mem_wr_lo_n, mem_rd_hi_n, mem_rd_lo_n} == {~ln, 2'b11}, "R1",
            "write strobes", 64'({mem_wr_hi_n, mem_wr_lo_n, mem_rd_hi_n, mem_rd_lo_n}),
            64'({~ln, 2'b11}));
        chk(mem_addr == row, "R9", "write row", 64'(mem_addr), 64'(row));
        chk(mem_wdata == wd && mem_wdata_oe, "R2", "write data lanes", mem_wdata, wd);
        chk(!rsp_done && !req_ready, "R3", "busy during write", 64'(rsp_done), 64'd0);
        if (frc > 0) begin a = 1'b0; frc--; end
        else a = ($urandom_range(99) >= pct);
        mem_ack = a;
        @(negedge clk);
      end while (!a);
      mem_ack = 1'b1;
      chk(rsp_done && !rsp_err, "R3", "write done", {62'd0, rsp_done, rsp_err}, 64'd2);
      chk(mem_cs_n && mem_wr_lo_n && mem_wr_hi_n, "R7", "idle after write", 64'(mem_cs_n), 64'd1);
    end else begin
      do begin
        chk({mem_wr_hi_n, mem_wr_lo_n, mem_rd_hi_n, mem_rd_lo_n} == {2'b11, ~ln}, "R1",
            "read strobes", 64'({mem_wr_hi_n, mem_wr_lo_n, mem_rd_hi_n, mem_rd_lo_n}),
            64'({2'b11, ~ln}));
        chk(mem_burst == burst, "R5", "burst in address phase", 64'(mem_burst), 64'(burst));
        chk(mem_addr == row, "R9", "read row", 64'(mem_addr), 64'(row));
        chk(!rsp_beat && !rsp_done, "R4", "no response in address phase", 64'(rsp_beat), 64'd0);
        if (frc > 0) begin a = 1'b0; frc--; end
        else a = ($urandom_range(99) >= pct);
        mem_ack = a;
        @(negedge clk);
      end while (!a);
      for (int b = 0; b < nb; b++) begin
        bit first;
        first = 1'b1;
        do begin
          chk(mem_addr == exp_row(row, b), burst ? "R5" : "R9", "data phase row",
              64'(mem_addr), 64'(exp_row(row, b)));
          chk(mem_burst == (burst && b != nb - 1), "R5", "burst line per beat",
              64'(mem_burst), 64'(burst && b != nb - 1));
          chk({mem_rd_hi_n, mem_rd_lo_n} == ~ln && !mem_cs_n, "R4", "strobes held in data phase",
              64'({mem_rd_hi_n, mem_rd_lo_n}), 64'(~ln));
          if (first && b > 0) begin
            chk(rsp_beat && !rsp_done, "R5", "mid-burst beat", {62'd0, rsp_beat, rsp_done}, 64'd2);
            chk(rsp_rdata == last_rd, "R2", "beat data", rsp_rdata, last_rd);
          end else begin
            chk(!rsp_beat, "R4", "no beat while waiting", 64'(rsp_beat), 64'd0);
          end
          first = 1'b0;
          mem_rdata = {$urandom, $urandom};
          if (frc > 0) begin a = 1'b0; frc--; end
          else a = ($urandom_range(99) >= pct);
          mem_ack = a;
          if (a) last_rd = keep_lanes(mem_rdata, ln);
          @(negedge clk);
        end while (!a);
      end
      mem_ack = 1'b1;
      chk(rsp_beat && rsp_done && !rsp_err, "R4", "read done",
          {61'd0, rsp_beat, rsp_done, rsp_err}, 64'd6);
      chk(rsp_rdata == last_rd, "R2", "read data lanes", rsp_rdata, last_rd);
      chk(mem_cs_n && !mem_burst, "R7", "idle after read", 64'(mem_cs_n), 64'd1);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    chk(mem_cs_n && mem_rd_lo_n && mem_rd_hi_n && mem_wr_lo_n && mem_wr_hi_n && !mem_burst,
        "R8", "bus idle in reset", 64'(mem_cs_n), 64'd1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_done && !rsp_err && !rsp_beat && rsp_rdata == 64'd0, "R8", "response after reset",
        rsp_rdata, 64'd0);
    chk(req_ready && mem_cs_n, "R8", "ready after reset", 64'(req_ready), 64'd1);

    // Directed: single-lane and wide accesses with ack tied high.
    run(1'b1, 1'b0, 1'b0, 10'h024, 64'h1111_2222_3333_4444, 0, 0);
    run(1'b1, 1'b0, 1'b0, 10'h025, 64'h5555_6666_7777_8888, 0, 0);
    run(1'b1, 1'b1, 1'b0, 10'h0F0, 64'hDEAD_BEEF_CAFE_F00D, 0, 0);
    run(1'b0, 1'b0, 1'b0, 10'h010, 64'd0, 0, 0);
    run(1'b0, 1'b0, 1'b0, 10'h011, 64'd0, 0, 0);
    run(1'b0, 1'b1, 1'b0, 10'h3FE, 64'd0, 0, 0);
    // Bursts from row low bits 00 and 11 (wrap).
    run(1'b0, 1'b1, 1'b1, 10'h040, 64'd0, 0, 0);
    run(1'b0, 1'b1, 1'b1, 10'h0C6, 64'd0, 0, 0);
    // Refused bursts.
    run(1'b1, 1'b1, 1'b1, 10'h100, 64'h1, 0, 0);
    run(1'b0, 1'b0, 1'b1, 10'h101, 64'd0, 0, 0);
    // Forced stalls: write stretched three cycles, read in both phases.
    run(1'b1, 1'b0, 1'b0, 10'h2A1, 64'hA5A5_A5A5_5A5A_5A5A, 0, 3);
    run(1'b0, 1'b1, 1'b0, 10'h2A2, 64'd0, 0, 2);
    run(1'b0, 1'b1, 1'b1, 10'h2A4, 64'd0, 0, 4);

    // Constrained random mix with idle gaps.
    for (int i = 0; i < 400; i++) begin
      bit wr, wide, burst;
      wr    = $urandom_range(1);
      wide  = $urandom_range(1);
      burst = ($urandom_range(3) == 0);
      if ($urandom_range(3) == 0) begin
        @(negedge clk);
        chk(mem_cs_n && req_ready && !rsp_done, "R7", "idle gap", 64'(mem_cs_n), 64'd1);
      end
      run(wr, wide, burst, AW'($urandom), {$urandom, $urandom}, 30, 0);
    end

    @(negedge clk);
    finish_run();
  end

endmodule